// File: doc/BRIEF.md
# Interrupt Status Summary Register

This block is the host-facing interrupt summary for a bus controller that runs a script-executing sequencer. It gathers individual event strobes from the bus-side protocol logic and from the DMA side, latches each in a sticky per-source detail bit, and presents one 8-bit summary register. That register carries a connection flag, a non-halting software interrupt flag, and one pending bit for each of the two source groups. A single interrupt line goes high while anything in the summary is pending.

Software reads the summary register first. If only the software flag is set, software clears it by writing a one to its bit before it looks at anything else; the sequencer keeps running throughout. If a group pending bit is set, software reads that group's detail registers. Each read returns the latched causes and clears them, and the group pending bit drops once all of that group's detail bits are clear.

The register port is a small address space. Address 0 is the summary. The bus-side detail registers follow, eight sources per register. The DMA detail register comes last. Read data is combinational on the cycle the read strobe is high, and the clear-on-read takes effect at the clock edge that ends that cycle.

Top module: `irq_status_summary`

## Requirements
- R1: A synchronous active-high reset clears the connection flag, the software flag and every detail bit. After reset the summary reads 0x00 and irq_o is low.
- R2: The connection flag (summary bit 3) is set one clock after any of the following: a successful selection (sel_done_i), a response to a selection or reselection from the bus (bus_sel_i), or an arbitration win (arb_win_i) while low_level_i is high. An arbitration win with low_level_i low leaves the flag unchanged.
- R3: link_drop_i clears the connection flag on the next clock, and it takes priority over a set event in the same cycle.
- R4: onfly_set_i sets the software flag (summary bit 2) on the next clock. Reading any address leaves the flag unchanged.
- R5: A write to address 0 with data bit 2 high clears the software flag in one cycle. A write to address 0 with bit 2 low, or a write to any other address, has no effect. A set strobe in the same cycle as the clear leaves the flag set.
- R6: A pulse on bus_ev_i[i] latches a sticky bit at address 1 + i/8, bit i%8. With 11 sources, address 1 bits 0..7 hold sources 0..7, address 2 bits 0..2 hold sources 8..10, and the remaining bits of address 2 read 0.
- R7: A pulse on dma_ev_i[j] latches a sticky bit at the DMA detail address (address 3 by default), bit j, for j in 0..5. Bits 6..7 read 0.
- R8: Summary bit 1 is high exactly when any bus-side detail bit is set. Summary bit 0 is high exactly when any DMA detail bit is set.
- R9: A read of a detail address returns the latched value and clears that register at the end of the read cycle. A read of one bus-side detail register leaves the other unchanged. Reading the summary clears no detail bit.
- R10: If an event strobe arrives in the same cycle as the clear-on-read of its detail register, the read returns the old value and the new bit stays set afterwards.
- R11: irq_o is high exactly when summary bit 2, 1 or 0 is high. The connection flag alone does not raise it.
- R12: Summary bits 7..4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_done_i | input | 1 | Strobe: own selection completed |
| bus_sel_i | input | 1 | Strobe: responded to selection/reselection from the bus |
| arb_win_i | input | 1 | Strobe: arbitration won |
| low_level_i | input | 1 | Level: low-level operating mode |
| link_drop_i | input | 1 | Strobe: device left the bus |
| onfly_set_i | input | 1 | Strobe: non-halting interrupt instruction executed |
| bus_ev_i | input | BUS_SRC | Bus-side interrupt source strobes |
| dma_ev_i | input | DMA_SRC | DMA-side interrupt source strobes |
| reg_addr_i | input | AW | Register address |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid while reg_rd_i is high |
| irq_o | output | 1 | Interrupt request line |

## Verification
The bench builds the block with its defaults: eleven bus-side sources and six DMA sources. With eleven sources the bus-side detail spans two registers, and the second is only partly filled. That lets the bench show that sources past bit 7 land in the second register and that its unused upper bits read zero. It also lets the bench show that reading one bus-side register leaves the summary pending until the other is read. Six DMA sources give a single detail register, which the bench uses to check that an event landing in the same cycle as a clear-on-read survives the read.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_CONN  = 3;
  localparam int BIT_ONFLY = 2;
  localparam int BIT_BUSP  = 1;
  localparam int BIT_DMAP  = 0;

  // number of REG_W-wide registers needed to hold n sources
  function automatic int regs_for(input int n);
    return (n + REG_W - 1) / REG_W;
  endfunction

  // register index (1-based after the summary) that holds bus source i
  function automatic int bus_reg_of(input int i);
    return 1 + i / REG_W;
  endfunction

  function automatic logic [REG_W-1:0] pack_summary(input logic conn,
                                                    input logic onfly,
                                                    input logic busp,
                                                    input logic dmap);
    logic [REG_W-1:0] s;
    s = '0;
    s[BIT_CONN]  = conn;
    s[BIT_ONFLY] = onfly;
    s[BIT_BUSP]  = busp;
    s[BIT_DMAP]  = dmap;
    return s;
  endfunction
endpackage

// File: rtl/irqs_conn_flag.sv
module irqs_conn_flag (
  input  logic clk,
  input  logic rst,
  input  logic sel_done_i,
  input  logic bus_sel_i,
  input  logic arb_win_i,
  input  logic low_level_i,
  input  logic link_drop_i,
  output logic conn_o
);
  logic conn_q;
  logic conn_set;

  assign conn_set = sel_done_i | bus_sel_i | (arb_win_i & low_level_i);

  always_ff @(posedge clk) begin
    if (rst)              conn_q <= 1'b0;
    else if (link_drop_i) conn_q <= 1'b0;
    else if (conn_set)    conn_q <= 1'b1;
  end

  assign conn_o = conn_q;
endmodule

// File: rtl/irqs_onfly_flag.sv
module irqs_onfly_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irqs_sticky_bank.sv
module irqs_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)          q[b] <= 1'b0;
      else if (ev_i[b]) q[b] <= 1'b1;
      else if (clr_i[b]) q[b] <= 1'b0;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/irq_status_summary.sv
module irq_status_summary
  import irq_sum_pkg::*;
#(
  parameter int BUS_SRC = 11,
  parameter int DMA_SRC = 6,
  localparam int BUS_REGS = (BUS_SRC + 7) / 8,
  localparam int AW = $clog2(BUS_REGS + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_done_i,
  input  logic               bus_sel_i,
  input  logic               arb_win_i,
  input  logic               low_level_i,
  input  logic               link_drop_i,
  input  logic               onfly_set_i,
  input  logic [BUS_SRC-1:0] bus_ev_i,
  input  logic [DMA_SRC-1:0] dma_ev_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic               reg_rd_i,
  input  logic               reg_wr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  output logic               irq_o
);
  localparam int BUS_PAD_W = BUS_REGS * REG_W;
  localparam int DMA_ADDR  = BUS_REGS + 1;

  // named internal events, observed by the checker
  logic               conn_q;
  logic               onfly_q;
  logic               onfly_clr;
  logic [BUS_SRC-1:0] bus_det;
  logic [DMA_SRC-1:0] dma_det;
  logic [BUS_SRC-1:0] bus_clr;
  logic [DMA_SRC-1:0] dma_clr;
  logic               bus_pend;
  logic               dma_pend;
  logic               sum_sel;
  logic               dma_sel;
  logic [BUS_PAD_W-1:0] bus_pad;
  logic               wdata_unused;

  assign sum_sel = (reg_addr_i == AW'(0));
  assign dma_sel = (reg_addr_i == AW'(DMA_ADDR));
  assign onfly_clr = reg_wr_i & sum_sel & reg_wdata_i[BIT_ONFLY];
  assign wdata_unused = ^{reg_wdata_i[7:BIT_ONFLY+1], reg_wdata_i[BIT_ONFLY-1:0]};

  irqs_conn_flag u_conn (
    .clk        (clk),
    .rst        (rst),
    .sel_done_i (sel_done_i),
    .bus_sel_i  (bus_sel_i),
    .arb_win_i  (arb_win_i),
    .low_level_i(low_level_i),
    .link_drop_i(link_drop_i),
    .conn_o     (conn_q)
  );

  irqs_onfly_flag u_onfly (
    .clk   (clk),
    .rst   (rst),
    .set_i (onfly_set_i),
    .clr_i (onfly_clr),
    .flag_o(onfly_q)
  );

  for (genvar i = 0; i < BUS_SRC; i++) begin : g_bus_clr
    assign bus_clr[i] = reg_rd_i & (reg_addr_i == AW'(bus_reg_of(i)));
  end
  assign dma_clr = {DMA_SRC{reg_rd_i & dma_sel}};

  irqs_sticky_bank #(.W(BUS_SRC)) u_bus_bank (
    .clk  (clk),
    .rst  (rst),
    .ev_i (bus_ev_i),
    .clr_i(bus_clr),
    .q_o  (bus_det)
  );

  irqs_sticky_bank #(.W(DMA_SRC)) u_dma_bank (
    .clk  (clk),
    .rst  (rst),
    .ev_i (dma_ev_i),
    .clr_i(dma_clr),
    .q_o  (dma_det)
  );

  assign bus_pend = |bus_det;
  assign dma_pend = |dma_det;
  assign bus_pad  = BUS_PAD_W'(bus_det);

  always_comb begin
    reg_rdata_o = '0;
    if (sum_sel) begin
      reg_rdata_o = pack_summary(conn_q, onfly_q, bus_pend, dma_pend);
    end else if (dma_sel) begin
      reg_rdata_o = REG_W'(dma_det);
    end else begin
      for (int r = 0; r < BUS_REGS; r++) begin
        if (reg_addr_i == AW'(r + 1)) reg_rdata_o = bus_pad[r*REG_W +: REG_W];
      end
    end
  end

  assign irq_o = onfly_q | bus_pend | dma_pend;
endmodule

// File: rtl/irqs_checker.sv
module irqs_checker #(
  parameter int BUS_SRC = 11,
  parameter int DMA_SRC = 6,
  parameter int AW = 2,
  parameter int DMA_ADDR = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               link_drop_i,
  input logic               onfly_set_i,
  input logic [BUS_SRC-1:0] bus_ev_i,
  input logic [DMA_SRC-1:0] dma_ev_i,
  input logic [AW-1:0]      reg_addr_i,
  input logic               reg_rd_i,
  input logic [7:0]         reg_rdata_o,
  input logic               irq_o,
  input logic               conn_q,
  input logic               onfly_q,
  input logic               onfly_clr,
  input logic               bus_pend,
  input logic               dma_pend,
  input logic [DMA_SRC-1:0] dma_det
);
  AST_ONFLY_SET: assert property (@(posedge clk) disable iff (rst)
    onfly_set_i |=> onfly_q); // R4
  AST_ONFLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (onfly_q && !onfly_clr) |=> onfly_q); // R4
  AST_ONFLY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (onfly_clr && !onfly_set_i) |=> !onfly_q); // R5
  AST_CONN_DROP: assert property (@(posedge clk) disable iff (rst)
    link_drop_i |=> !conn_q); // R3
  AST_BUS_LATCH: assert property (@(posedge clk) disable iff (rst)
    (bus_ev_i != '0) |=> bus_pend); // R6
  AST_DMA_LATCH: assert property (@(posedge clk) disable iff (rst)
    (dma_ev_i != '0) |=> dma_pend); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (dma_ev_i[0] && reg_rd_i && reg_addr_i == AW'(DMA_ADDR)) |=> dma_det[0]); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (!onfly_q && !bus_pend && !dma_pend)); // R11
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && reg_addr_i == '0) |-> (reg_rdata_o[7:4] == 4'h0)); // R12
endmodule

bind irq_status_summary irqs_checker #(
  .BUS_SRC (BUS_SRC),
  .DMA_SRC (DMA_SRC),
  .AW      (AW),
  .DMA_ADDR(DMA_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .link_drop_i(link_drop_i),
  .onfly_set_i(onfly_set_i),
  .bus_ev_i   (bus_ev_i),
  .dma_ev_i   (dma_ev_i),
  .reg_addr_i (reg_addr_i),
  .reg_rd_i   (reg_rd_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .conn_q     (conn_q),
  .onfly_q    (onfly_q),
  .onfly_clr  (onfly_clr),
  .bus_pend   (bus_pend),
  .dma_pend   (dma_pend),
  .dma_det    (dma_det)
);

// File: tb/irq_status_summary_test.sv
`timescale 1ns/1ps
module irq_status_summary_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_done_i = 0, bus_sel_i = 0, arb_win_i = 0, low_level_i = 0;
  logic        link_drop_i = 0, onfly_set_i = 0;
  logic [10:0] bus_ev_i = '0;
  logic [5:0]  dma_ev_i = '0;
  logic [1:0]  reg_addr_i = '0;
  logic        reg_rd_i = 0, reg_wr_i = 0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #2.5 clk = ~clk;

  irq_status_summary uut (
    .clk(clk), .rst(rst), .sel_done_i(sel_done_i), .bus_sel_i(bus_sel_i),
    .arb_win_i(arb_win_i), .low_level_i(low_level_i), .link_drop_i(link_drop_i),
    .onfly_set_i(onfly_set_i), .bus_ev_i(bus_ev_i), .dma_ev_i(dma_ev_i),
    .reg_addr_i(reg_addr_i), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  // monitor: compare each read against the next scoreboard entry
  always @(negedge clk) begin
    #1;
    if (reg_rd_i) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata_o !== e) begin
        errors++;
        $display("FAIL %s read addr %0d: got %02h expected %02h", t, reg_addr_i, reg_rdata_o, e);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr_i = a; reg_rd_i = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd_i = 0;
  endtask

  task automatic rd_dma_ev(input logic [1:0] a, input logic [7:0] e,
                           input logic [5:0] ev, input string t);
    @(negedge clk);
    reg_addr_i = a; reg_rd_i = 1; dma_ev_i = ev;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd_i = 0; dma_ev_i = '0;
  endtask

  task automatic rd_bus_ev(input logic [1:0] a, input logic [7:0] e,
                           input logic [10:0] ev, input string t);
    @(negedge clk);
    reg_addr_i = a; reg_rd_i = 1; bus_ev_i = ev;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd_i = 0; bus_ev_i = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic set_too);
    @(negedge clk);
    reg_addr_i = a; reg_wr_i = 1; reg_wdata_i = d; onfly_set_i = set_too;
    @(negedge clk);
    reg_wr_i = 0; onfly_set_i = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    #1;
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s irq_o: got %b expected %b", t, irq_o, e);
    end
  endtask

  task automatic pulse_conn(input logic sd, input logic bs, input logic aw, input logic dr);
    @(negedge clk);
    sel_done_i = sd; bus_sel_i = bs; arb_win_i = aw; link_drop_i = dr;
    @(negedge clk);
    sel_done_i = 0; bus_sel_i = 0; arb_win_i = 0; link_drop_i = 0;
  endtask

  task automatic pulse_bus(input logic [10:0] v);
    @(negedge clk); bus_ev_i = v;
    @(negedge clk); bus_ev_i = '0;
  endtask

  task automatic pulse_dma(input logic [5:0] v);
    @(negedge clk); dma_ev_i = v;
    @(negedge clk); dma_ev_i = '0;
  endtask

  task automatic pulse_onfly();
    @(negedge clk); onfly_set_i = 1;
    @(negedge clk); onfly_set_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(2'd0, 8'h00, "R1 summary after reset");
    rd(2'd1, 8'h00, "R1 bus detail lo after reset");
    rd(2'd3, 8'h00, "R1 dma detail after reset");
    chk_irq(1'b0, "R1");

    // R2 connection sources
    pulse_conn(0, 0, 1, 0);
    rd(2'd0, 8'h00, "R2 arb win outside low-level mode");
    low_level_i = 1;
    pulse_conn(0, 0, 1, 0);
    rd(2'd0, 8'h08, "R2 arb win in low-level mode");
    low_level_i = 0;
    chk_irq(1'b0, "R11 connection alone");
    pulse_conn(0, 0, 0, 1);
    rd(2'd0, 8'h00, "R3 drop clears");
    pulse_conn(1, 0, 0, 0);
    rd(2'd0, 8'h08, "R2 selection done");
    pulse_conn(0, 0, 0, 1);
    pulse_conn(0, 1, 0, 0);
    rd(2'd0, 8'h08, "R2 bus selection response");
    pulse_conn(0, 1, 0, 1);
    rd(2'd0, 8'h00, "R3 drop beats set");

    // R4 / R5 software flag
    pulse_onfly();
    rd(2'd0, 8'h04, "R4 flag set");
    rd(2'd0, 8'h04, "R4 flag survives read");
    chk_irq(1'b1, "R11 software flag");
    wr(2'd0, 8'hFB, 0);
    rd(2'd0, 8'h04, "R5 write with bit2 low ignored");
    wr(2'd1, 8'hFF, 0);
    rd(2'd0, 8'h04, "R5 write to other address ignored");
    rd(2'd1, 8'h00, "R5 other address not written");
    wr(2'd0, 8'h04, 0);
    rd(2'd0, 8'h00, "R5 write one clears");
    chk_irq(1'b0, "R5 irq drops");
    wr(2'd0, 8'h04, 1);
    rd(2'd0, 8'h04, "R5 set beats clear");
    wr(2'd0, 8'h04, 0);

    // R6 / R8 / R9 bus group
    pulse_bus(11'b100_0000_0101);
    rd(2'd0, 8'h02, "R8 bus pending");
    chk_irq(1'b1, "R11 bus pending");
    rd(2'd1, 8'h05, "R6 bus detail lo");
    rd(2'd0, 8'h02, "R9 pending held by hi register");
    rd(2'd2, 8'h04, "R6 bus detail hi, upper bits zero");
    rd(2'd0, 8'h00, "R9 pending drops after reads");
    rd(2'd2, 8'h00, "R9 hi cleared by read");
    chk_irq(1'b0, "R9 irq drops");
    pulse_bus(11'b000_0000_1000);
    pulse_bus(11'b000_0001_0000);
    rd(2'd1, 8'h18, "R6 sticky accumulation");
    rd(2'd1, 8'h00, "R9 lo cleared by read");

    // R7 / R8 dma group
    pulse_dma(6'b100001);
    rd(2'd0, 8'h01, "R8 dma pending");
    rd(2'd3, 8'h21, "R7 dma detail");
    rd(2'd0, 8'h00, "R8 dma pending drops");

    // R10 event beats clear-on-read
    pulse_dma(6'b000001);
    rd_dma_ev(2'd3, 8'h01, 6'b000010, "R10 read returns old dma value");
    rd(2'd3, 8'h02, "R10 new dma event kept");
    rd_bus_ev(2'd1, 8'h00, 11'b000_1000_0000, "R10 bus read during event");
    rd(2'd1, 8'h80, "R10 new bus event kept");

    // R12 all summary bits together
    pulse_conn(1, 0, 0, 0);
    pulse_onfly();
    pulse_bus(11'b010_0000_0000);
    pulse_dma(6'b001000);
    rd(2'd0, 8'h0F, "R12 full summary, upper nibble zero");

    // R1 reset again clears everything
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd(2'd0, 8'h00, "R1 summary after second reset");
    rd(2'd2, 8'h00, "R1 bus hi after second reset");
    chk_irq(1'b0, "R1 irq after second reset");

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule